// File: doc/BRIEF.md
# Four-Channel Double-Buffered DAC Register File

This block is the host-facing register file for four 12-bit digital-to-analog converter channels. The host reaches it through a simple synchronous register port: a write strobe, a read strobe, a byte address and a 16-bit write word. For each channel the block keeps a staging register for the code and a staging copy of the channel's range, meaning a polarity flag and a gain flag. It also keeps an active copy of both, and the active copy drives the external converter pins.

A two-bit control register governs the block. One bit enables the converters and the other selects buffered mode. With buffered mode off, a code or range write goes straight to the active outputs. With buffered mode on, writes only fill the staging registers. The host then commits them by issuing a read to one of two update addresses. One update address moves all four codes at once. The other moves all the range flags at once. Every channel therefore changes on the same clock edge.

While the enable bit is clear, every active output reads as zero and both update strobes do nothing. The read strobe carries no data back, because the update addresses exist only for their side effect.

Top module: `quad_dac_regs`

## Requirements
- R1: After a synchronous active-low reset, every code, polarity and gain output is zero. The control and staging registers are also zero, so an enable followed by both update strobes still leaves every output zero.
- R2: A code write keeps only bits 11:0 of the write word. Bits 15:12 are dropped.
- R3: With enable=1 and buffered=0, a code write to channel n changes that channel's code output on the clock edge that takes the write. No other channel changes. The code addresses are 0x14, 0x16, 0x18 and 0x1A for channels 0 to 3.
- R4: With enable=1 and buffered=1, a code write changes no output. A read of address 0x02 then copies all four staged codes to the outputs on the same edge.
- R5: The control register is written at address 0x02. Write bit 1 is the enable and bit 0 is buffered mode. All other write bits are ignored.
- R6: A range write goes to address 0x12. Polarity for channel n comes from write bit 7-n, and gain for channel n comes from write bit 11-n. With buffered=0 the range reaches the outputs on the same edge. With buffered=1 it reaches them only on a read of address 0x12.
- R7: While enable=0, all code, polarity and gain outputs are zero. The outputs become zero on the edge that takes the disabling control write. Update strobes issued while disabled have no effect.
- R8: Re-enabling does not bring back the outputs held before the disable. The outputs stay zero until a new write (unbuffered) or an update strobe.
- R9: When the write and read strobes are both high in one cycle, the write is performed and the read is ignored.
- R10: Writes and reads at any other address change no output and no staged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe (update trigger) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write word |
| dac_code_o | output | 48 | Active codes, channel n in bits 12n+11:12n |
| dac_bipolar_o | output | 4 | Active polarity flag per channel |
| dac_gain_o | output | 4 | Active gain flag per channel |

## Verification
The bench builds the block with its default parameters: four channels, 12-bit codes, an 8-bit address and a 16-bit write word. These values make the reversed range packing and all four code addresses reachable, and the dropped bits 15:12 can be driven. Random operations mix code, range, control and stray-address accesses, with enable and buffered mode toggling throughout. This reaches disable and re-enable in the middle of staging, and strobes issued in both modes. Directed cases cover simultaneous write and read, and checking that each polarity and gain bit lands on the channel its position names.

// File: rtl/quad_dac_pkg.sv
// Package: shared address map, range-field positions and control type for
// the quad DAC register file. Assumes byte addressing with 16-bit registers.
package quad_dac_pkg;

    // Address map (byte offsets)
    localparam int unsigned ADDR_CTRL      = 'h02;  // write: control, read: code update
    localparam int unsigned ADDR_RANGE     = 'h12;  // write: range, read: range update
    localparam int unsigned ADDR_DATA_BASE = 'h14;  // channel n at base + 2n
    localparam int unsigned ADDR_STRIDE    = 2;

    // Range field: flag for channel n sits at MSB - n
    localparam int unsigned BIP_MSB  = 7;
    localparam int unsigned GAIN_MSB = 11;

    // Control bit positions
    localparam int unsigned CTRL_EN_BIT  = 1;
    localparam int unsigned CTRL_BUF_BIT = 0;

    typedef struct packed {
        logic en;
        logic buffered;
    } dac_ctrl_t;

endpackage

// File: rtl/quad_dac_decode.sv
// Module: address decoder. Turns the host strobes into one-cycle register
// selects. Assumes at most one access per cycle; a write masks a read.
module quad_dac_decode #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              ctrl_we,
    output logic              range_we,
    output logic [NUM_CH-1:0] data_we,
    output logic              code_upd,
    output logic              range_upd
);
    import quad_dac_pkg::*;

    logic rd_eff;

    // Read is honoured only when no write shares the cycle
    assign rd_eff = rd_en & ~wr_en;

    // Fixed register selects
    always_comb begin
        ctrl_we   = wr_en  && (addr == ADDR_W'(ADDR_CTRL));
        range_we  = wr_en  && (addr == ADDR_W'(ADDR_RANGE));
        code_upd  = rd_eff && (addr == ADDR_W'(ADDR_CTRL));
        range_upd = rd_eff && (addr == ADDR_W'(ADDR_RANGE));
    end

    // One code-register select per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dsel
        localparam int unsigned CH_ADDR = ADDR_DATA_BASE + ADDR_STRIDE * ch;
        assign data_we[ch] = wr_en && (addr == ADDR_W'(CH_ADDR));
    end

endmodule

// File: rtl/quad_dac_ctrl.sv
// Module: control register holding the converter enable and the
// buffered-mode select. Resets to disabled and unbuffered.
module quad_dac_ctrl (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic                   en_bit,
    input  logic                   buf_bit,
    output quad_dac_pkg::dac_ctrl_t ctrl
);
    // Capture the two control bits on a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (we) begin
            ctrl.en       <= en_bit;
            ctrl.buffered <= buf_bit;
        end
    end

endmodule

// File: rtl/quad_dac_channel.sv
// Module: one converter channel with staging and active copies of the code
// and range flags. Uses the control value from before the current edge;
// while disabled, the active copy is cleared and strobes are ignored.
module quad_dac_channel #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              buffered,
    input  logic              data_we,
    input  logic              range_we,
    input  logic              code_upd,
    input  logic              range_upd,
    input  logic [CODE_W-1:0] wcode,
    input  logic              wbip,
    input  logic              wgain,
    output logic [CODE_W-1:0] act_code,
    output logic              act_bip,
    output logic              act_gain
);
    logic [CODE_W-1:0] stg_code;
    logic              stg_bip;
    logic              stg_gain;
    logic              direct;

    assign direct = en & ~buffered;

    // Staging registers follow every matching write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_code <= '0;
            stg_bip  <= 1'b0;
            stg_gain <= 1'b0;
        end else begin
            if (data_we) stg_code <= wcode;
            if (range_we) begin
                stg_bip  <= wbip;
                stg_gain <= wgain;
            end
        end
    end

    // Active code: cleared when disabled, direct write or update strobe otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            act_code <= '0;
        end else if (data_we && direct) begin
            act_code <= wcode;
        end else if (code_upd) begin
            act_code <= stg_code;
        end
    end

    // Active range: same policy on the range strobe
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            act_bip  <= 1'b0;
            act_gain <= 1'b0;
        end else if (range_we && direct) begin
            act_bip  <= wbip;
            act_gain <= wgain;
        end else if (range_upd) begin
            act_bip  <= stg_bip;
            act_gain <= stg_gain;
        end
    end

endmodule

// File: rtl/quad_dac_regs.sv
// Module: top of the quad DAC register file. Joins the decoder, control
// register and per-channel registers, and gates the outputs with the enable.
// Assumes NUM_CH <= 4 so that the range flags fit the packed field.
module quad_dac_regs #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 12,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr_en,
    input  logic                     bus_rd_en,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [NUM_CH*CODE_W-1:0] dac_code_o,
    output logic [NUM_CH-1:0]        dac_bipolar_o,
    output logic [NUM_CH-1:0]        dac_gain_o
);
    import quad_dac_pkg::*;

    dac_ctrl_t         ctrl;
    logic              ctrl_we;
    logic              range_we;
    logic [NUM_CH-1:0] data_we;
    logic              code_upd;
    logic              range_upd;

    logic              ctrl_en;
    logic              ctrl_buf;

    assign ctrl_en  = ctrl.en;
    assign ctrl_buf = ctrl.buffered;

    quad_dac_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .wr_en     (bus_wr_en),
        .rd_en     (bus_rd_en),
        .addr      (bus_addr),
        .ctrl_we   (ctrl_we),
        .range_we  (range_we),
        .data_we   (data_we),
        .code_upd  (code_upd),
        .range_upd (range_upd)
    );

    quad_dac_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctrl_we),
        .en_bit  (bus_wdata[CTRL_EN_BIT]),
        .buf_bit (bus_wdata[CTRL_BUF_BIT]),
        .ctrl    (ctrl)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [CODE_W-1:0] code_q;
        logic              bip_q;
        logic              gain_q;

        quad_dac_channel #(
            .CODE_W (CODE_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (ctrl_en),
            .buffered  (ctrl_buf),
            .data_we   (data_we[ch]),
            .range_we  (range_we),
            .code_upd  (code_upd),
            .range_upd (range_upd),
            .wcode     (bus_wdata[CODE_W-1:0]),
            .wbip      (bus_wdata[BIP_MSB - ch]),
            .wgain     (bus_wdata[GAIN_MSB - ch]),
            .act_code  (code_q),
            .act_bip   (bip_q),
            .act_gain  (gain_q)
        );

        // Output gating: zero as soon as the enable drops
        always_comb begin
            dac_code_o[ch*CODE_W +: CODE_W] = ctrl_en ? code_q : '0;
            dac_bipolar_o[ch]               = ctrl_en & bip_q;
            dac_gain_o[ch]                  = ctrl_en & gain_q;
        end
    end

endmodule

// File: rtl/quad_dac_regs_chk.sv
// Module: property checker for quad_dac_regs, attached by bind. Watches the
// host port, the outputs and the control register state.
module quad_dac_regs_chk #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 12,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr_en,
    input logic                     bus_rd_en,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [DATA_W-1:0]        bus_wdata,
    input logic [NUM_CH*CODE_W-1:0] dac_code_o,
    input logic [NUM_CH-1:0]        dac_bipolar_o,
    input logic [NUM_CH-1:0]        dac_gain_o,
    input logic                     ctrl_en,
    input logic                     ctrl_buf
);
    import quad_dac_pkg::*;

    logic hit_ctrl, hit_range, hit_data0;
    assign hit_ctrl  = (bus_addr == ADDR_W'(ADDR_CTRL));
    assign hit_range = (bus_addr == ADDR_W'(ADDR_RANGE));
    assign hit_data0 = (bus_addr == ADDR_W'(ADDR_DATA_BASE));

    // R1: reset leaves all outputs at zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (dac_code_o == '0 && dac_bipolar_o == '0 && dac_gain_o == '0));

    // R2 and R3: an unbuffered channel-0 write shows its low 12 bits next cycle
    assert_direct_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && hit_data0 && ctrl_en && !ctrl_buf)
        |=> dac_code_o[CODE_W-1:0] == $past(bus_wdata[CODE_W-1:0]));

    // R4: a buffered code write leaves every code output unchanged
    assert_staged_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && hit_data0 && ctrl_en && ctrl_buf) |=> $stable(dac_code_o));

    // R6: a buffered range write leaves the range outputs unchanged
    assert_range_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && hit_range && ctrl_en && ctrl_buf)
        |=> ($stable(dac_bipolar_o) && $stable(dac_gain_o)));

    // R7: a disabling control write zeroes the outputs on that edge
    assert_disable_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && hit_ctrl && !bus_wdata[CTRL_EN_BIT])
        |=> (dac_code_o == '0 && dac_bipolar_o == '0 && dac_gain_o == '0));

    // R7: strobes while disabled leave the outputs at zero
    assert_strobe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && bus_rd_en && !bus_wr_en && (hit_ctrl || hit_range))
        |=> (dac_code_o == '0 && dac_bipolar_o == '0 && dac_gain_o == '0));

endmodule

bind quad_dac_regs quad_dac_regs_chk #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr_en     (bus_wr_en),
    .bus_rd_en     (bus_rd_en),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .dac_code_o    (dac_code_o),
    .dac_bipolar_o (dac_bipolar_o),
    .dac_gain_o    (dac_gain_o),
    .ctrl_en       (ctrl_en),
    .ctrl_buf      (ctrl_buf)
);

// File: tb/quad_dac_regs_tb.sv
// Bench: directed corner cases plus seeded random operations, compared with
// a bench-side model written from the requirements.
module quad_dac_regs_tb;
    localparam int NCH = 4;
    localparam int CW  = 12;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            wr_en, rd_en;
    logic [7:0]      addr;
    logic [15:0]     wdata;
    logic [NCH*CW-1:0] code_o;
    logic [NCH-1:0]  bip_o, gain_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state
    bit         m_en, m_buf;
    logic [11:0] m_stg [NCH];
    logic [11:0] m_act [NCH];
    bit          m_sbip [NCH], m_sgain [NCH], m_abip [NCH], m_again [NCH];

    always #10 clk = ~clk;

    quad_dac_regs u_dut (
        .clk (clk), .rst_n (rst_n),
        .bus_wr_en (wr_en), .bus_rd_en (rd_en),
        .bus_addr (addr), .bus_wdata (wdata),
        .dac_code_o (code_o), .dac_bipolar_o (bip_o), .dac_gain_o (gain_o)
    );

    function automatic logic [NCH*CW-1:0] exp_code();
        logic [NCH*CW-1:0] v = '0;
        for (int c = 0; c < NCH; c++) if (m_en) v[c*CW +: CW] = m_act[c];
        return v;
    endfunction

    function automatic logic [NCH-1:0] exp_bip();
        logic [NCH-1:0] v = '0;
        for (int c = 0; c < NCH; c++) v[c] = m_en & m_abip[c];
        return v;
    endfunction

    function automatic logic [NCH-1:0] exp_gain();
        logic [NCH-1:0] v = '0;
        for (int c = 0; c < NCH; c++) v[c] = m_en & m_again[c];
        return v;
    endfunction

    task automatic model_reset();
        m_en = 0; m_buf = 0;
        for (int c = 0; c < NCH; c++) begin
            m_stg[c] = '0; m_act[c] = '0;
            m_sbip[c] = 0; m_sgain[c] = 0; m_abip[c] = 0; m_again[c] = 0;
        end
    endtask

    // Applies one access to the model; control changes take effect after the edge
    task automatic model_apply(bit w, bit r, logic [7:0] a, logic [15:0] d);
        bit rd = r & ~w;
        bit direct = m_en & ~m_buf;
        bit old_en = m_en;
        if (w) begin
            for (int c = 0; c < NCH; c++) begin
                if (a == 8'h14 + 8'(2*c)) begin
                    m_stg[c] = d[11:0];
                    if (direct) m_act[c] = d[11:0];
                end
            end
            if (a == 8'h12) begin
                for (int c = 0; c < NCH; c++) begin
                    m_sbip[c] = d[7-c]; m_sgain[c] = d[11-c];
                    if (direct) begin m_abip[c] = d[7-c]; m_again[c] = d[11-c]; end
                end
            end
        end
        if (rd && old_en) begin
            for (int c = 0; c < NCH; c++) begin
                if (a == 8'h02) m_act[c] = m_stg[c];
                if (a == 8'h12) begin m_abip[c] = m_sbip[c]; m_again[c] = m_sgain[c]; end
            end
        end
        if (!old_en) begin
            for (int c = 0; c < NCH; c++) begin
                m_act[c] = '0; m_abip[c] = 0; m_again[c] = 0;
            end
        end
        if (w && a == 8'h02) begin m_en = d[1]; m_buf = d[0]; end
    endtask

    task automatic check_out(string tag);
        checks++;
        if (code_o !== exp_code() || bip_o !== exp_bip() || gain_o !== exp_gain()) begin
            fails++;
            $display("FAIL %s code=%h/%h bip=%b/%b gain=%b/%b (actual/expected)",
                     tag, code_o, exp_code(), bip_o, exp_bip(), gain_o, exp_gain());
        end
    endtask

    // One bus cycle: drive at falling edge, sample at the next falling edge
    task automatic bus(bit w, bit r, logic [7:0] a, logic [15:0] d, string tag);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        model_apply(w, r, a, d);
        check_out(tag);
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d, string tag);
        bus(1, 0, a, d, tag);
    endtask

    task automatic rd(logic [7:0] a, string tag);
        bus(0, 1, a, 16'h0, tag);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        wr_en = 0; rd_en = 0; addr = '0; wdata = '0; rst_n = 0;
        model_reset();
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check_out("R1");
        rst_n = 1;
        @(negedge clk);
        check_out("R1");
        // R1: staged registers start at zero
        wr(8'h02, 16'h0003, "R1");
        rd(8'h02, "R1");
        rd(8'h12, "R1");

        // R3 and R2: unbuffered direct writes, upper bits dropped
        wr(8'h02, 16'h0002, "R5");
        wr(8'h14, 16'hFABC, "R2");
        wr(8'h16, 16'h0123, "R3");
        wr(8'h18, 16'h0456, "R3");
        wr(8'h1A, 16'h0FFF, "R3");

        // R5: extra control bits ignored; buffered mode on
        wr(8'h02, 16'hFFF3, "R5");
        // R4: staged writes hold until the update read
        wr(8'h14, 16'h0111, "R4");
        wr(8'h16, 16'h0222, "R4");
        wr(8'h18, 16'h0333, "R4");
        wr(8'h1A, 16'h0444, "R4");
        rd(8'h02, "R4");

        // R6: range packing, buffered then committed
        wr(8'h12, 16'h0880, "R6");
        rd(8'h12, "R6");
        wr(8'h12, 16'h0110, "R6");
        rd(8'h12, "R6");
        wr(8'h02, 16'h0002, "R6");
        wr(8'h12, 16'h0A50, "R6");

        // R9: write wins over simultaneous read
        wr(8'h02, 16'h0003, "R9");
        wr(8'h14, 16'h0777, "R9");
        bus(1, 1, 8'h14, 16'h0555, "R9");
        rd(8'h02, "R9");

        // R10: stray addresses do nothing
        wr(8'h00, 16'hFFFF, "R10");
        wr(8'h15, 16'hFFFF, "R10");
        rd(8'h14, "R10");
        rd(8'h02, "R10");

        // R7: disable zeroes outputs; strobes ignored while disabled
        wr(8'h14, 16'h0999, "R7");
        wr(8'h02, 16'h0001, "R7");
        rd(8'h02, "R7");
        rd(8'h12, "R7");
        // R8: re-enable keeps outputs at zero until an update
        wr(8'h02, 16'h0003, "R8");
        wr(8'h02, 16'h0002, "R8");
        wr(8'h02, 16'h0003, "R8");
        rd(8'h02, "R8");

        // Random mix of accesses
        for (int i = 0; i < 600; i++) begin
            int k = int'($urandom_range(0, 9));
            logic [15:0] d = 16'($urandom);
            case (k)
                0, 1, 2: wr(8'h14 + 8'(2 * $urandom_range(0, 3)), d, "R4");
                3:       wr(8'h02, {d[15:2], ($urandom_range(0, 4) != 0), d[0]}, "R5");
                4:       wr(8'h12, d, "R6");
                5, 6:    rd(8'h02, "R4");
                7:       rd(8'h12, "R6");
                8:       bus(1, 1, 8'($urandom), d, "R9");
                default: bus(($urandom_range(0, 1) == 1), 1'b1, 8'($urandom), d, "R10");
            endcase
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule